// File: doc/BRIEF.md
# Byte-Level Frame Builder and Checker with CRC-16

This block sits between a host-visible byte buffer and a modulator datapath. On the transmit side it reads a stored payload through a byte RAM read port and presents the complete over-the-air frame as a stream of bytes on a valid/ready interface. Each frame has a fixed run of zero preamble bytes, a delimiter byte, a length byte, the payload and a two-byte check sequence. A single completion pulse marks the end of a frame. A request for a payload that is too long is refused, and no byte leaves the block.

The receive side takes the demodulated byte stream on its own valid/ready interface. It searches for the delimiter, checks the length byte, writes the payload into a byte RAM write port and recomputes the check sequence over everything after the length byte. When the frame completes it reports the payload length, a pass/fail flag for the check sequence and a completion pulse.

Top module: `frame_codec`

## Requirements
- R1: A transmitted frame is, in order: 4 bytes of 0x00, the delimiter 0xA7, a length byte equal to the payload length plus 2, the payload bytes, then the two check bytes.
- R2: A start request with a length above 125 raises `tx_reject_o` for one cycle on the next clock and offers no byte (`tx_valid_o` stays low, `tx_busy_o` stays low).
- R3: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, initial value 0x0000, no final inversion, each data byte fed least significant bit first. It covers the payload only and is sent low byte first.
- R4: `tx_done_o` pulses for exactly one cycle, on the clock after the last check byte is accepted, and the transmitter is idle (`tx_busy_o` low) in that cycle.
- R5: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold their values.
- R6: Payload byte k of a transmitted frame is read from `tx_ram_addr_o` = k, with the read data taken in the same cycle.
- R7: For a received frame, payload byte k is written to `rx_ram_addr_o` = k with `rx_ram_we_o` high. One cycle after the last check byte arrives, `rx_done_o` pulses and `rx_len_o` holds the payload length (length byte minus 2).
- R8: A received length byte below 2 or above 127 drops the frame: no RAM write and no `rx_done_o`, and the receiver returns to searching for the delimiter.
- R9: A 0xA7 byte starts a frame only if the byte directly before it was 0x00. Otherwise it is ignored.
- R10: `rx_crc_ok_o` is set when a frame completes, to 1 if the received check bytes match the CRC computed over the received payload and to 0 if they do not. It clears on the cycle after the next accepted delimiter and otherwise holds its value.
- R11: A zero-length payload is legal on both sides. It is sent with length byte 0x02 and check bytes 0x00 0x00, and it is received with `rx_len_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_start_i | input | 1 | Request to send a frame of length `tx_len_i` (taken while idle) |
| tx_len_i | input | 8 | Payload length of the request |
| tx_busy_o | output | 1 | A frame is being sent |
| tx_reject_o | output | 1 | One-cycle pulse: the request length was too large |
| tx_done_o | output | 1 | One-cycle pulse: the frame has been sent |
| tx_ram_addr_o | output | 7 | Payload RAM read address |
| tx_ram_data_i | input | 8 | Payload RAM read data (combinational) |
| tx_data_o | output | 8 | Outgoing frame byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| rx_data_i | input | 8 | Incoming frame byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Receiver accepts a byte (always high) |
| rx_ram_we_o | output | 1 | Payload RAM write enable |
| rx_ram_addr_o | output | 7 | Payload RAM write address |
| rx_ram_wdata_o | output | 8 | Payload RAM write data |
| rx_len_o | output | 8 | Payload length of the last completed frame |
| rx_done_o | output | 1 | One-cycle pulse: a frame was received |
| rx_crc_ok_o | output | 1 | Check result of the last completed frame |

## Verification
The bench builds the block with its default parameters: four preamble bytes, delimiter 0xA7 and a 125-byte payload limit. With these values the longest legal frame (125 bytes, length byte 127) and the shortest refused request (126) can both be reached, and the receive length bounds at 1 and 128 sit on both sides of the legal window. Every address that the 7-bit RAM ports can take up to 124 is used. The 4-byte preamble also keeps transmit frames short enough that back-pressure can be applied in several different phases of the frame within a short run.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int          LEN_W     = 8;
  localparam logic [15:0] CRC_POLYR = 16'h8408;  // x^16+x^12+x^5+1, bit-reversed
  localparam int          FCS_BYTES = 2;

  typedef enum logic [2:0] {
    TX_IDLE, TX_PRE, TX_SFD, TX_LEN, TX_PAY, TX_FCS_LO, TX_FCS_HI
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_HUNT, RX_LEN, RX_BODY
  } rx_state_e;
endpackage

// File: rtl/crc16_byte.sv
module crc16_byte
  import framer_pkg::*;
(
  input  logic [15:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  always_comb begin
    logic [15:0] c;
    c = crc_i ^ {8'h00, data_i};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLYR) : (c >> 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import framer_pkg::*;
#(
  parameter int          PRE_LEN     = 4,
  parameter int          MAX_PAYLOAD = 125,
  parameter logic [7:0]  SFD_BYTE    = 8'hA7,
  localparam int         ADDR_W      = $clog2(MAX_PAYLOAD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              reject_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  input  logic              ready_i
);
  localparam logic [LEN_W-1:0] PRE_LAST = LEN_W'(PRE_LEN - 1);
  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_PAYLOAD);

  tx_state_e        state_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic [15:0]      crc_q, crc_nxt;
  logic             reject_q, done_q, hs;

  crc16_byte u_crc (.crc_i(crc_q), .data_i(ram_data_i), .crc_o(crc_nxt));

  assign hs         = valid_o && ready_i;
  assign valid_o    = (state_q != TX_IDLE);
  assign busy_o     = valid_o;
  assign reject_o   = reject_q;
  assign done_o     = done_q;
  assign ram_addr_o = cnt_q[ADDR_W-1:0];

  always_comb begin
    unique case (state_q)
      TX_SFD:    data_o = SFD_BYTE;
      TX_LEN:    data_o = len_q + LEN_W'(FCS_BYTES);
      TX_PAY:    data_o = ram_data_i;
      TX_FCS_LO: data_o = crc_q[7:0];
      TX_FCS_HI: data_o = crc_q[15:8];
      default:   data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      crc_q    <= '0;
      reject_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      reject_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          if (len_i > MAX_LEN) begin
            reject_q <= 1'b1;
          end else begin
            len_q   <= len_i;
            cnt_q   <= '0;
            crc_q   <= '0;
            state_q <= TX_PRE;
          end
        end
        TX_PRE: if (hs) begin
          if (cnt_q == PRE_LAST) begin
            cnt_q   <= '0;
            state_q <= TX_SFD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_SFD: if (hs) state_q <= TX_LEN;
        TX_LEN: if (hs) begin
          cnt_q   <= '0;
          state_q <= (len_q == '0) ? TX_FCS_LO : TX_PAY;
        end
        TX_PAY: if (hs) begin
          crc_q <= crc_nxt;
          if (cnt_q == len_q - 1'b1) state_q <= TX_FCS_LO;
          else                       cnt_q   <= cnt_q + 1'b1;
        end
        TX_FCS_LO: if (hs) state_q <= TX_FCS_HI;
        TX_FCS_HI: if (hs) begin
          state_q <= TX_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
  a_r2_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !valid_o);
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(hs));
  a_r6_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == TX_PAY |-> (ram_addr_o < ADDR_W'(MAX_PAYLOAD)));
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import framer_pkg::*;
#(
  parameter int          MAX_PAYLOAD = 125,
  parameter logic [7:0]  SFD_BYTE    = 8'hA7,
  localparam int         ADDR_W      = $clog2(MAX_PAYLOAD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              done_o,
  output logic              crc_ok_o
);
  localparam logic [LEN_W-1:0] MIN_FLEN = LEN_W'(FCS_BYTES);
  localparam logic [LEN_W-1:0] MAX_FLEN = LEN_W'(MAX_PAYLOAD + FCS_BYTES);

  rx_state_e        state_q;
  logic             pre_seen_q, ok_q, done_q;
  logic [LEN_W-1:0] flen_q, cnt_q, plen_q;
  logic [15:0]      crc_q, crc_nxt;
  logic             sfd_hit, len_bad;

  crc16_byte u_crc (.crc_i(crc_q), .data_i(data_i), .crc_o(crc_nxt));

  assign ready_o     = 1'b1;
  assign sfd_hit     = (state_q == RX_HUNT) && valid_i && (data_i == SFD_BYTE) && pre_seen_q;
  assign len_bad     = (data_i < MIN_FLEN) || (data_i > MAX_FLEN);
  assign ram_we_o    = (state_q == RX_BODY) && valid_i && (cnt_q < flen_q - MIN_FLEN);
  assign ram_addr_o  = cnt_q[ADDR_W-1:0];
  assign ram_wdata_o = data_i;
  assign len_o       = plen_q;
  assign done_o      = done_q;
  assign crc_ok_o    = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_HUNT;
      pre_seen_q <= 1'b0;
      ok_q       <= 1'b0;
      done_q     <= 1'b0;
      flen_q     <= '0;
      cnt_q      <= '0;
      plen_q     <= '0;
      crc_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RX_HUNT: if (valid_i) begin
          if (sfd_hit) begin
            pre_seen_q <= 1'b0;
            ok_q       <= 1'b0;
            state_q    <= RX_LEN;
          end else begin
            pre_seen_q <= (data_i == 8'h00);
          end
        end
        RX_LEN: if (valid_i) begin
          if (len_bad) begin
            state_q <= RX_HUNT;
          end else begin
            flen_q  <= data_i;
            cnt_q   <= '0;
            crc_q   <= '0;
            state_q <= RX_BODY;
          end
        end
        RX_BODY: if (valid_i) begin
          crc_q <= crc_nxt;
          if (cnt_q == flen_q - 1'b1) begin
            ok_q    <= (crc_nxt == 16'h0000);  // residue of data plus its own CRC
            done_q  <= 1'b1;
            plen_q  <= flen_q - MIN_FLEN;
            state_q <= RX_HUNT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  a_r7_we_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o < ADDR_W'(MAX_PAYLOAD)));
  a_r8_len_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_LEN) && valid_i && (data_i > MAX_FLEN) |=> state_q == RX_HUNT && !done_o);
  a_r9_sfd_needs_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_HUNT) && valid_i && (data_i == SFD_BYTE) && !pre_seen_q |=> state_q == RX_HUNT);
  a_r10_ok_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(crc_ok_o) |-> done_o || $past(sfd_hit));
endmodule

// File: rtl/frame_codec.sv
module frame_codec
  import framer_pkg::*;
#(
  parameter int          PRE_LEN     = 4,
  parameter int          MAX_PAYLOAD = 125,
  parameter logic [7:0]  SFD_BYTE    = 8'hA7,
  localparam int         ADDR_W      = $clog2(MAX_PAYLOAD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_start_i,
  input  logic [7:0]        tx_len_i,
  output logic              tx_busy_o,
  output logic              tx_reject_o,
  output logic              tx_done_o,
  output logic [ADDR_W-1:0] tx_ram_addr_o,
  input  logic [7:0]        tx_ram_data_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              rx_ram_we_o,
  output logic [ADDR_W-1:0] rx_ram_addr_o,
  output logic [7:0]        rx_ram_wdata_o,
  output logic [7:0]        rx_len_o,
  output logic              rx_done_o,
  output logic              rx_crc_ok_o
);
  frame_tx #(
    .PRE_LEN(PRE_LEN), .MAX_PAYLOAD(MAX_PAYLOAD), .SFD_BYTE(SFD_BYTE)
  ) u_tx (
    .clk_i, .rst_ni,
    .start_i   (tx_start_i),
    .len_i     (tx_len_i),
    .busy_o    (tx_busy_o),
    .reject_o  (tx_reject_o),
    .done_o    (tx_done_o),
    .ram_addr_o(tx_ram_addr_o),
    .ram_data_i(tx_ram_data_i),
    .data_o    (tx_data_o),
    .valid_o   (tx_valid_o),
    .ready_i   (tx_ready_i)
  );

  frame_rx #(
    .MAX_PAYLOAD(MAX_PAYLOAD), .SFD_BYTE(SFD_BYTE)
  ) u_rx (
    .clk_i, .rst_ni,
    .data_i     (rx_data_i),
    .valid_i    (rx_valid_i),
    .ready_o    (rx_ready_o),
    .ram_we_o   (rx_ram_we_o),
    .ram_addr_o (rx_ram_addr_o),
    .ram_wdata_o(rx_ram_wdata_o),
    .len_o      (rx_len_o),
    .done_o     (rx_done_o),
    .crc_ok_o   (rx_crc_ok_o)
  );
endmodule

// File: tb/frame_codec_tb.sv
module frame_codec_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start_i = 1'b0, tx_ready_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0] tx_len_i = '0, rx_data_i = '0;
  logic [6:0] tx_ram_addr_o, rx_ram_addr_o;
  logic [7:0] tx_ram_data_i, tx_data_o, rx_ram_wdata_o, rx_len_o;
  logic       tx_busy_o, tx_reject_o, tx_done_o, tx_valid_o;
  logic       rx_ready_o, rx_ram_we_o, rx_done_o, rx_crc_ok_o;

  logic [7:0] tx_mem [128];
  logic [7:0] rx_mem [128];
  logic [7:0] pay    [128];
  int checks = 0, errors = 0, rx_done_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign tx_ram_data_i = tx_mem[tx_ram_addr_o];

  always @(posedge clk) if (rx_ram_we_o) rx_mem[rx_ram_addr_o] <= rx_ram_wdata_o;
  always @(negedge clk) if (rx_done_o) rx_done_cnt++;

  frame_codec u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_start_i, .tx_len_i, .tx_busy_o, .tx_reject_o, .tx_done_o,
    .tx_ram_addr_o, .tx_ram_data_i, .tx_data_o, .tx_valid_o, .tx_ready_i,
    .rx_data_i, .rx_valid_i, .rx_ready_o, .rx_ram_we_o, .rx_ram_addr_o,
    .rx_ram_wdata_o, .rx_len_o, .rx_done_o, .rx_crc_ok_o
  );

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] r = 16'h0000;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ pay[i][b];
        r  = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'h8408;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_valid_o && !tx_busy_o && !tx_done_o, "R4 reset tx idle", tx_valid_o, 0);
    chk(!rx_done_o && !rx_crc_ok_o && rx_ready_o, "R10 reset rx", rx_crc_ok_o, 0);
  endtask

  // R1 R3 R4 R5 R6 R11: send one frame and compare every byte
  task automatic t_tx_frame(input int len, input bit stall, input int seed);
    logic [7:0] got [136];
    logic [7:0] exp_b [136];
    logic [15:0] c;
    int n = 0, cyc = 0, bad = -1;
    bit held = 0;
    logic [7:0] held_d = '0;
    for (int i = 0; i < 128; i++) tx_mem[i] = 8'((i * 37 + seed) & 255);
    for (int i = 0; i < len; i++) pay[i] = tx_mem[i];
    c = ref_crc(len);
    for (int i = 0; i < 4; i++) exp_b[i] = 8'h00;
    exp_b[4] = 8'hA7;
    exp_b[5] = 8'(len + 2);
    for (int i = 0; i < len; i++) exp_b[6+i] = pay[i];
    exp_b[6+len] = c[7:0];
    exp_b[7+len] = c[15:8];
    @(negedge clk);
    tx_len_i = 8'(len); tx_start_i = 1'b1;
    @(negedge clk);
    tx_start_i = 1'b0;
    while (n < len + 8 && cyc < 2000) begin
      tx_ready_i = !(stall && (cyc % 3 == 1));
      #1;
      if (held) chk(tx_valid_o && tx_data_o == held_d, "R5 stall hold", tx_data_o, held_d);
      held = tx_valid_o && !tx_ready_i;
      held_d = tx_data_o;
      if (tx_valid_o && tx_ready_i) begin
        got[n] = tx_data_o;
        n++;
      end
      cyc++;
      @(negedge clk);
    end
    tx_ready_i = 1'b0;
    chk(n == len + 8, "R1 byte count", n, len + 8);
    chk(tx_done_o && !tx_busy_o, "R4 done pulse", tx_done_o, 1);
    for (int i = 0; i < len + 6; i++) if (bad < 0 && got[i] != exp_b[i]) bad = i;
    chk(bad < 0, (len == 0) ? "R11 empty frame header" : "R1 R6 frame bytes",
        (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : exp_b[bad]);
    chk({got[len+7], got[len+6]} == c, "R3 FCS", {got[len+7], got[len+6]}, c);
    @(negedge clk);
    chk(!tx_done_o, "R4 done single cycle", tx_done_o, 0);
  endtask

  task automatic t_tx_reject(input int len);
    @(negedge clk);
    tx_len_i = 8'(len); tx_start_i = 1'b1;
    @(negedge clk);
    tx_start_i = 1'b0;
    chk(tx_reject_o && !tx_valid_o, "R2 reject pulse", tx_reject_o, 1);
    repeat (3) begin
      @(negedge clk);
      chk(!tx_valid_o && !tx_busy_o && !tx_reject_o, "R2 nothing sent", tx_valid_o, 0);
    end
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data_i = b; rx_valid_i = 1'b1;
  endtask

  task automatic rx_idle();
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  // R7 R10 R11: deliver a frame, optionally with a wrong check byte
  task automatic t_rx_frame(input int len, input int npre, input bit corrupt, input int seed);
    logic [15:0] c;
    int bad = -1;
    for (int i = 0; i < len; i++) pay[i] = 8'((i * 11 + seed) & 255);
    c = ref_crc(len);
    if (corrupt) c = c ^ 16'h0100;
    for (int i = 0; i < npre; i++) rx_byte(8'h00);
    rx_byte(8'hA7);
    rx_byte(8'(len + 2));
    for (int i = 0; i < len; i++) rx_byte(pay[i]);
    rx_byte(c[7:0]);
    rx_byte(c[15:8]);
    rx_idle();
    chk(rx_done_o, "R7 rx done", rx_done_o, 1);
    chk(rx_len_o == 8'(len), (len == 0) ? "R11 rx empty length" : "R7 rx length", rx_len_o, len);
    chk(rx_crc_ok_o == !corrupt, "R10 crc result", rx_crc_ok_o, !corrupt);
    for (int i = 0; i < len; i++) if (bad < 0 && rx_mem[i] != pay[i]) bad = i;
    chk(bad < 0, "R7 rx payload", (bad < 0) ? 0 : rx_mem[bad], (bad < 0) ? 0 : pay[bad]);
    @(negedge clk);
    chk(!rx_done_o, "R7 done single cycle", rx_done_o, 0);
  endtask

  task automatic t_rx_bad_len();
    int c0 = rx_done_cnt;
    rx_mem[0] = 8'h5A;
    rx_byte(8'h00); rx_byte(8'hA7); rx_byte(8'h01);
    for (int i = 0; i < 4; i++) rx_byte(8'h33);
    rx_byte(8'h00); rx_byte(8'hA7); rx_byte(8'h80);
    for (int i = 0; i < 6; i++) rx_byte(8'h44);
    rx_idle();
    repeat (2) @(negedge clk);
    chk(rx_done_cnt == c0, "R8 bad length dropped", rx_done_cnt - c0, 0);
    chk(rx_mem[0] == 8'h5A, "R8 no RAM write", rx_mem[0], 8'h5A);
    t_rx_frame(3, 1, 0, 9);
  endtask

  task automatic t_rx_sfd_rules();
    int c0;
    t_rx_frame(2, 2, 0, 4);
    c0 = rx_done_cnt;
    rx_byte(8'h55); rx_byte(8'hA7); rx_byte(8'h02); rx_byte(8'h00); rx_byte(8'h00);
    rx_idle();
    repeat (2) @(negedge clk);
    chk(rx_done_cnt == c0, "R9 delimiter without preamble ignored", rx_done_cnt - c0, 0);
    chk(rx_crc_ok_o, "R10 flag held", rx_crc_ok_o, 1);
    rx_byte(8'h00); rx_byte(8'hA7);
    @(negedge clk);
    rx_valid_i = 1'b0;
    chk(!rx_crc_ok_o, "R10 flag cleared at delimiter", rx_crc_ok_o, 0);
    rx_byte(8'h02); rx_byte(8'h00); rx_byte(8'h00);
    rx_idle();
    chk(rx_done_o && rx_crc_ok_o && rx_len_o == 0, "R9 R11 frame after preamble", rx_len_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_frame(5, 0, 1);
    t_tx_frame(17, 1, 3);
    t_tx_frame(0, 1, 0);
    t_tx_frame(125, 1, 7);
    t_tx_reject(126);
    t_tx_reject(255);
    t_tx_frame(1, 0, 2);
    t_rx_frame(6, 4, 0, 1);
    t_rx_frame(125, 4, 0, 5);
    t_rx_frame(10, 1, 1, 8);
    t_rx_frame(0, 3, 0, 0);
    t_rx_bad_len();
    t_rx_sfd_rules();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule